// File: doc/BRIEF.md
# Boot Strap Latch and Boot Region Remapper

This block captures two boot-selection strap pins at a fixed point after reset and decides which memory the processor boots from: main flash, system memory or embedded SRAM. The capture happens on exactly the fourth rising clock edge after reset is released. It happens again, on the same edge count, after each pulse that signals the device is leaving standby. Between capture points, the straps are ignored.

The captured choice is shown three ways: as a two-bit code, as a valid flag, and as three one-hot select lines. The block also redirects fetch addresses that fall in the boot window at address zero to the base of the selected memory, so the processor's first fetches land in the chosen space.

Top module: `boot_strap_latch`

## Requirements
- R1: While reset is asserted (`rst_n` low), `boot_valid` is 0, all three selects are 0, and `mapped_addr` equals `fetch_addr`.
- R2: After reset is released, the straps are captured on the 4th rising clock edge. `boot_valid` is 0 after edges 1 to 3 and becomes 1 on edge 4. The capture uses the strap values present at edge 4.
- R3: Decoding of the captured straps. `strap_lo`=0 gives code 0 (main flash) for either value of `strap_hi`. `strap_lo`=1 with `strap_hi`=0 gives code 1 (system memory). `strap_lo`=1 with `strap_hi`=1 gives code 2 (embedded SRAM).
- R4: Strap changes at any edge other than a capture edge leave `boot_mode` unchanged.
- R5: A clock edge that samples `standby_exit` high clears `boot_valid`. The straps are then captured again on the 4th edge after that one, and `boot_valid` rises there.
- R6: If `standby_exit` is high on an edge that would have been a capture edge, or on any edge inside a capture window, the count restarts and no capture happens on that edge. This applies to windows started by reset and to windows started by an earlier standby exit.
- R7: When `boot_valid` is 1, exactly one select is high: `sel_flash` for code 0, `sel_sysmem` for code 1, `sel_sram` for code 2. When `boot_valid` is 0, all three selects are 0.
- R8: Address remapping. When `boot_valid` is 1 and `fetch_addr` is below 2^ALIAS_W (0x1000 by default), `mapped_addr` is the selected base plus `fetch_addr`. The default bases are 0x0800_0000 (flash), 0x1FFF_F000 (system memory) and 0x2000_0000 (SRAM). In every other case `mapped_addr` equals `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_exit | input | 1 | One-cycle pulse on wake-up from standby |
| strap_lo | input | 1 | Boot strap pin, low bit |
| strap_hi | input | 1 | Boot strap pin, high bit |
| fetch_addr | input | ADDR_W | Address issued by the processor |
| boot_mode | output | 2 | Latched boot code |
| boot_valid | output | 1 | High once a capture has completed |
| sel_flash | output | 1 | Main flash selected |
| sel_sysmem | output | 1 | System memory selected |
| sel_sram | output | 1 | Embedded SRAM selected |
| mapped_addr | output | ADDR_W | Address after boot window remapping |

## Verification
Two events can fall on the same clock edge: a due capture and a standby-exit restart. The bench raises `standby_exit` on the exact edge where a capture would happen. It does this once in a window started by reset and once in a window started by an earlier standby exit. It also raises the pulse once partway through a window. In each case the bench confirms that `boot_valid` stays low and that the mode finally taken is the strap value present four edges after the last pulse, not the value present at the abandoned capture edge.

// File: rtl/boot_latch_pkg.sv
`timescale 1ns/1ps
package boot_latch_pkg;

    typedef enum logic [1:0] {
        BM_FLASH  = 2'd0,
        BM_SYSMEM = 2'd1,
        BM_SRAM   = 2'd2
    } boot_mode_e;

    // Strap decode: low strap clear always means flash
    function automatic boot_mode_e strap_decode(input logic hi, input logic lo);
        if (!lo)
            return BM_FLASH;
        else if (!hi)
            return BM_SYSMEM;
        else
            return BM_SRAM;
    endfunction

endpackage

// File: rtl/bootlatch_timer.sv
`timescale 1ns/1ps
module bootlatch_timer #(
    parameter int SAMPLE_EDGE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic fire
);
    localparam int CNT_W = $clog2(SAMPLE_EDGE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_EDGE - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = '0;
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.active = 1'b0;
                tmr_d.cnt    = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    // Window opens out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.active <= 1'b1;
            tmr_q.cnt    <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign fire = tmr_q.active && (tmr_q.cnt == LAST) && !restart;

endmodule

// File: rtl/bootlatch_select.sv
`timescale 1ns/1ps
module bootlatch_select
    import boot_latch_pkg::*;
(
    input  boot_mode_e mode,
    input  logic       valid,
    output logic [2:0] sel
);
    always_comb begin
        sel = 3'b000;
        if (valid) begin
            unique case (mode)
                BM_FLASH:  sel = 3'b001;
                BM_SYSMEM: sel = 3'b010;
                BM_SRAM:   sel = 3'b100;
                default:   sel = 3'b000;
            endcase
        end
    end
endmodule

// File: rtl/bootlatch_remap.sv
`timescale 1ns/1ps
module bootlatch_remap #(
    parameter int              ADDR_W     = 32,
    parameter int              ALIAS_W    = 12,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] SYS_BASE   = 32'h1FFF_F000,
    parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [2:0]        sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - ALIAS_W;
    localparam logic [ADDR_W-1:0] BASES [3] = '{FLASH_BASE, SYS_BASE, SRAM_BASE};

    logic              in_window;
    logic [ADDR_W-1:0] base_or [4];

    assign in_window = (addr_in[ADDR_W-1:ALIAS_W] == HI_W'(0));

    // OR-reduce the bases picked by the one-hot select
    assign base_or[0] = '0;
    for (genvar g = 0; g < 3; g++) begin : g_base
        assign base_or[g+1] = base_or[g] | (sel[g] ? BASES[g] : '0);
    end

    assign addr_out = (in_window && (sel != 3'b000)) ? base_or[3] + addr_in : addr_in;

endmodule

// File: rtl/boot_strap_latch.sv
`timescale 1ns/1ps
module boot_strap_latch
    import boot_latch_pkg::*;
#(
    parameter int              SAMPLE_EDGE = 4,
    parameter int              ADDR_W      = 32,
    parameter int              ALIAS_W     = 12,
    parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] SYS_BASE    = 32'h1FFF_F000,
    parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_exit,
    input  logic              strap_lo,
    input  logic              strap_hi,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        boot_mode,
    output logic              boot_valid,
    output logic              sel_flash,
    output logic              sel_sysmem,
    output logic              sel_sram,
    output logic [ADDR_W-1:0] mapped_addr
);
    typedef struct packed {
        boot_mode_e mode;
        logic       valid;
    } latch_t;

    latch_t     st_d, st_q;
    logic       fire;
    logic [2:0] sel;

    bootlatch_timer #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (standby_exit),
        .fire    (fire)
    );

    always_comb begin
        st_d = st_q;
        if (standby_exit) begin
            st_d.valid = 1'b0;
        end else if (fire) begin
            st_d.mode  = strap_decode(strap_hi, strap_lo);
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= BM_FLASH;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    bootlatch_select u_sel (
        .mode  (st_q.mode),
        .valid (st_q.valid),
        .sel   (sel)
    );

    bootlatch_remap #(
        .ADDR_W     (ADDR_W),
        .ALIAS_W    (ALIAS_W),
        .FLASH_BASE (FLASH_BASE),
        .SYS_BASE   (SYS_BASE),
        .SRAM_BASE  (SRAM_BASE)
    ) u_remap (
        .addr_in  (fetch_addr),
        .sel      (sel),
        .addr_out (mapped_addr)
    );

    assign boot_mode  = st_q.mode;
    assign boot_valid = st_q.valid;
    assign sel_flash  = sel[0];
    assign sel_sysmem = sel[1];
    assign sel_sram   = sel[2];

endmodule

// File: rtl/bootlatch_checker.sv
`timescale 1ns/1ps
module bootlatch_checker #(
    parameter int              SAMPLE_EDGE = 4,
    parameter int              ADDR_W      = 32,
    parameter int              ALIAS_W     = 12,
    parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_exit,
    input logic              strap_lo,
    input logic              strap_hi,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [1:0]        boot_mode,
    input logic              boot_valid,
    input logic              sel_flash,
    input logic              sel_sysmem,
    input logic              sel_sram,
    input logic [ADDR_W-1:0] mapped_addr
);
    localparam int SW = $clog2(SAMPLE_EDGE + 1);
    localparam logic [SW-1:0] LIM = SW'(SAMPLE_EDGE);

    logic [SW-1:0] since_q;
    logic [1:0]    want_mode;

    // Edges since reset release or last standby exit, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= '0;
        else if (standby_exit)
            since_q <= '0;
        else if (since_q < LIM)
            since_q <= since_q + 1'b1;
    end

    assign want_mode = !strap_lo ? 2'd0 : (!strap_hi ? 2'd1 : 2'd2);

    // R2 / R5 / R6: no valid before the window has run out
    a_r2_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < LIM) |-> !boot_valid);

    a_r5_rise_on_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_valid) |-> (since_q == LIM));

    a_r5_drop_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        standby_exit |=> !boot_valid);

    a_r3_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_valid) |-> (boot_mode == $past(want_mode)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_valid && $past(boot_valid)) |-> $stable(boot_mode));

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |-> ($countones({sel_flash, sel_sysmem, sel_sram}) == 1));

    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_valid |-> ({sel_flash, sel_sysmem, sel_sram} == 3'b000));

    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_valid |-> (mapped_addr == fetch_addr));

    a_r8_sram: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sram && (fetch_addr < (ADDR_W'(1) << ALIAS_W))) |-> (mapped_addr == SRAM_BASE + fetch_addr));

endmodule

bind boot_strap_latch bootlatch_checker #(
    .SAMPLE_EDGE (SAMPLE_EDGE),
    .ADDR_W      (ADDR_W),
    .ALIAS_W     (ALIAS_W),
    .SRAM_BASE   (SRAM_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_exit (standby_exit),
    .strap_lo     (strap_lo),
    .strap_hi     (strap_hi),
    .fetch_addr   (fetch_addr),
    .boot_mode    (boot_mode),
    .boot_valid   (boot_valid),
    .sel_flash    (sel_flash),
    .sel_sysmem   (sel_sysmem),
    .sel_sram     (sel_sram),
    .mapped_addr  (mapped_addr)
);

// File: tb/tb_boot_strap_latch.sv
`timescale 1ns/1ps
module tb_boot_strap_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_exit = 1'b0;
    logic        strap_lo = 1'b0;
    logic        strap_hi = 1'b0;
    logic [31:0] fetch_addr = 32'h0;
    logic [1:0]  boot_mode;
    logic        boot_valid;
    logic        sel_flash, sel_sysmem, sel_sram;
    logic [31:0] mapped_addr;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] B_FLASH = 32'h0800_0000;
    localparam logic [31:0] B_SYS   = 32'h1FFF_F000;
    localparam logic [31:0] B_SRAM  = 32'h2000_0000;

    always #2 clk = ~clk;

    boot_strap_latch dut (
        .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit),
        .strap_lo(strap_lo), .strap_hi(strap_hi), .fetch_addr(fetch_addr),
        .boot_mode(boot_mode), .boot_valid(boot_valid),
        .sel_flash(sel_flash), .sel_sysmem(sel_sysmem), .sel_sram(sel_sram),
        .mapped_addr(mapped_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic hi, input logic lo);
        return !lo ? 2'd0 : (!hi ? 2'd1 : 2'd2);
    endfunction

    function automatic logic [2:0] exp_sel(input logic [1:0] c);
        return (c == 2'd0) ? 3'b001 : (c == 2'd1) ? 3'b010 : 3'b100;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_captured(input string req, input logic hi, input logic lo);
        check({req, " valid"}, 32'(boot_valid), 32'd1);
        check({req, " code"}, 32'(boot_mode), 32'(exp_code(hi, lo)));
        check("R7 selects", 32'({sel_sram, sel_sysmem, sel_flash}), 32'(exp_sel(exp_code(hi, lo))));
    endtask

    // Reset, release, and run edges 1..3 with the opposite straps
    task automatic reset_to_edge3(input logic hi, input logic lo);
        @(negedge clk);
        rst_n = 1'b0; standby_exit = 1'b0;
        strap_hi = ~hi; strap_lo = ~lo;
        tick();
        rst_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_addr = 32'h0000_0010;
        tick();
        #1;
        check("R1 valid in reset", 32'(boot_valid), 32'd0);
        check("R1 selects in reset", 32'({sel_sram, sel_sysmem, sel_flash}), 32'd0);
        check("R1 address passthrough", mapped_addr, 32'h0000_0010);
    endtask

    task automatic test_boot(input logic hi, input logic lo);
        reset_to_edge3(hi, lo);
        check("R2 not valid after edge 3", 32'(boot_valid), 32'd0);
        strap_hi = hi; strap_lo = lo;
        tick();
        check_captured("R2 R3 capture on edge 4", hi, lo);
    endtask

    task automatic test_ignore();
        test_boot(1'b1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            strap_hi = i[0]; strap_lo = i[1];
            tick();
            check("R4 straps ignored", 32'(boot_mode), 32'd2);
        end
    endtask

    task automatic test_standby(input logic hi, input logic lo);
        standby_exit = 1'b1;
        tick();
        standby_exit = 1'b0;
        check("R5 valid drops on exit", 32'(boot_valid), 32'd0);
        check("R7 selects cleared", 32'({sel_sram, sel_sysmem, sel_flash}), 32'd0);
        strap_hi = ~hi; strap_lo = ~lo;
        repeat (3) tick();
        check("R5 not valid at exit+3", 32'(boot_valid), 32'd0);
        strap_hi = hi; strap_lo = lo;
        tick();
        check_captured("R5 recapture at exit+4", hi, lo);
    endtask

    task automatic test_collide();
        // Reset window: exit lands on the capture edge
        reset_to_edge3(1'b0, 1'b1);
        strap_hi = 1'b0; strap_lo = 1'b1;
        standby_exit = 1'b1;
        tick();
        standby_exit = 1'b0;
        check("R6 no capture on reset collision", 32'(boot_valid), 32'd0);
        strap_hi = 1'b1; strap_lo = 1'b1;
        repeat (3) tick();
        check("R6 still waiting", 32'(boot_valid), 32'd0);
        tick();
        check_captured("R6 capture after restart", 1'b1, 1'b1);
        // Standby window: exit lands on the capture edge, then mid-window
        standby_exit = 1'b1;
        tick();
        standby_exit = 1'b0;
        repeat (3) tick();
        strap_hi = 1'b0; strap_lo = 1'b1;
        standby_exit = 1'b1;
        tick();
        standby_exit = 1'b0;
        check("R6 no capture on exit collision", 32'(boot_valid), 32'd0);
        tick();
        standby_exit = 1'b1;
        tick();
        standby_exit = 1'b0;
        strap_hi = 1'b0; strap_lo = 1'b0;
        repeat (3) tick();
        check("R6 mid-window restart", 32'(boot_valid), 32'd0);
        tick();
        check_captured("R6 final capture", 1'b0, 1'b0);
    endtask

    task automatic test_remap(input logic hi, input logic lo, input logic [31:0] base);
        test_boot(hi, lo);
        fetch_addr = 32'h0000_0123;
        #1;
        check("R8 window remap", mapped_addr, base + 32'h123);
        fetch_addr = 32'h0000_0FFC;
        #1;
        check("R8 window top", mapped_addr, base + 32'hFFC);
        fetch_addr = 32'h0000_1000;
        #1;
        check("R8 outside window", mapped_addr, 32'h0000_1000);
        fetch_addr = 32'h0800_0040;
        #1;
        check("R8 direct address", mapped_addr, 32'h0800_0040);
    endtask

    initial begin
        test_reset();
        test_boot(1'b0, 1'b0);
        test_boot(1'b1, 1'b0);
        test_boot(1'b0, 1'b1);
        test_boot(1'b1, 1'b1);
        test_ignore();
        test_standby(1'b0, 1'b1);
        test_standby(1'b1, 1'b0);
        test_collide();
        test_remap(1'b0, 1'b0, B_FLASH);
        test_remap(1'b0, 1'b1, B_SYS);
        test_remap(1'b1, 1'b1, B_SRAM);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule